// File: doc/BRIEF.md
# Interrupt Context Bank Controller

This block sits beside the exception sequencer of a processor core and decides, on every exception entry, where the core's working context goes. A maskable interrupt taken while banking is switched on copies the context into a hardware bank slot: fifteen general registers, the global base register, the two multiply-accumulate halves, the procedure return register and the vector table offset of the interrupt. Every other exception class leaves the banks alone. When all slots are already taken, a configuration flag picks one of two outcomes. The context can go to the stack instead, or a bank-overflow exception can be raised.

Occupied slots form a last-in, first-out stack. The bank number counts the slots in use. A restore strobe from the return path takes back the most recently saved slot and presents its contents on the restore outputs. All decision and status outputs are registered and change on the clock edge that samples the request.

Top module: `irq_ctx_bank_ctrl`

## Requirements
- R1: After reset the bank number is 0, the full flag is low and the save, fallback, overflow, bank-error and restore-valid pulses are all low.
- R2: An entry with class code 3'd0 (maskable interrupt), with banking enabled and the bank number below NUM_BANKS, pulses bank_save_o for one cycle after the sampling edge and raises the bank number by one on that edge.
- R3: Entries with class codes 3'd1 (NMI), 3'd2 (user break), 3'd3 (address error), 3'd4 (bank error) and 3'd5 (instruction trap) produce no save, fallback or overflow pulse and leave the bank number and the slot contents unchanged.
- R4: A maskable interrupt entry while bank_en_i is low produces no save, fallback or overflow pulse and leaves the bank number unchanged.
- R5: A maskable interrupt entry with banking enabled, all slots occupied and ovf_exc_en_i low pulses stack_fallback_o, with no save or overflow pulse and no change to the bank number.
- R6: The same entry with ovf_exc_en_i high pulses bank_ovf_exc_o, with no save or fallback pulse and no change to the bank number.
- R7: A restore with the bank number above 0 lowers it by one and pulses restore_valid_o. The restore outputs carry the context and vector offset of the most recent save still held, so slots come back in last-in, first-out order.
- R8: A restore with the bank number at 0 pulses bank_err_o, keeps the bank number at 0 and leaves restore_valid_o low.
- R9: bank_full_o is high exactly while the bank number equals NUM_BANKS.
- R10: When restore_i and entry_valid_i are high in the same cycle, the restore is ignored and only the entry is acted on.
- R11: At most one of bank_save_o, stack_fallback_o and bank_ovf_exc_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_valid_i | input | 1 | Exception entry request this cycle |
| exc_class_i | input | 3 | Exception class code |
| bank_en_i | input | 1 | Register banking enabled |
| ovf_exc_en_i | input | 1 | Raise overflow exception instead of stack fallback when full |
| vec_ofs_i | input | VOFS_W | Vector table offset of the exception |
| ctx_regs_i | input | 19*DATA_W | Context to save: R0..R14, GBR, MACH, MACL, PR (R0 in the low word) |
| restore_i | input | 1 | Restore strobe from the return path |
| bank_save_o | output | 1 | Context was written into a bank slot |
| stack_fallback_o | output | 1 | Banks full; context goes to the stack |
| bank_ovf_exc_o | output | 1 | Banks full; bank-overflow exception requested |
| bank_err_o | output | 1 | Restore requested with no occupied slot |
| restore_valid_o | output | 1 | Restore outputs hold a popped slot |
| rest_ctx_o | output | 19*DATA_W | Restored context |
| rest_vofs_o | output | VOFS_W | Restored vector offset |
| bank_num_o | output | CNT_W | Number of occupied slots |
| bank_full_o | output | 1 | All slots occupied |

## Verification
The bench builds the block with NUM_BANKS=3, DATA_W=8 and VOFS_W=6. Three slots fill in three entries, so both full-bank outcomes, a restore and re-save around the full boundary, and a complete drain down to a restore-on-empty error all fit in a short run. The narrow data words keep every context distinct, which lets the bench detect a slot returned out of order.

// File: rtl/ctxbank_pkg.sv
package ctxbank_pkg;

    // Exception class codes seen at entry; only EXC_IRQ may be banked.
    typedef enum logic [2:0] {
        EXC_IRQ     = 3'd0,
        EXC_NMI     = 3'd1,
        EXC_UBRK    = 3'd2,
        EXC_ADDR    = 3'd3,
        EXC_BANKERR = 3'd4,
        EXC_TRAP    = 3'd5
    } exc_class_e;

    // General registers R0..R14 plus GBR, MACH, MACL, PR.
    localparam int unsigned CTX_REGS = 19;

endpackage

// File: rtl/ctxbank_decide.sv
module ctxbank_decide #(
    parameter int unsigned NUM_BANKS = 15,
    parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input  logic             entry_valid,
    input  logic [2:0]       exc_class,
    input  logic             bank_en,
    input  logic             ovf_en,
    input  logic [CNT_W-1:0] bank_num,
    output logic             take_bank,
    output logic             take_stack,
    output logic             raise_ovf
);
    import ctxbank_pkg::*;

    localparam logic [CNT_W-1:0] BN_MAX = CNT_W'(NUM_BANKS);

    logic bankable;
    logic all_used;

    always_comb begin
        bankable   = entry_valid && (exc_class == EXC_IRQ) && bank_en;
        all_used   = (bank_num == BN_MAX);
        take_bank  = bankable && !all_used;
        take_stack = bankable && all_used && !ovf_en;
        raise_ovf  = bankable && all_used && ovf_en;
    end

endmodule

// File: rtl/ctxbank_store.sv
module ctxbank_store #(
    parameter int unsigned NUM_BANKS = 15,
    parameter int unsigned SLOT_W    = 32,
    parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [SLOT_W-1:0] rd_data
);

    logic [SLOT_W-1:0] slot_q [NUM_BANKS];
    logic [SLOT_W-1:0] rd_d, rd_q;

    for (genvar s = 0; s < NUM_BANKS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en && (wr_idx == CNT_W'(s)))
                slot_q[s] <= wr_data;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            for (int s = 0; s < NUM_BANKS; s++) begin
                if (rd_idx == CNT_W'(s))
                    rd_d = slot_q[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < CNT_W'(NUM_BANKS))) else $error("write past last slot"); // R5
    AST_NO_RW_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)) else $error("read and write in one cycle"); // R10

endmodule

// File: rtl/irq_ctx_bank_ctrl.sv
module irq_ctx_bank_ctrl #(
    parameter int unsigned NUM_BANKS = 15,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned VOFS_W    = 10,
    parameter int unsigned CTX_W     = ctxbank_pkg::CTX_REGS * DATA_W,
    parameter int unsigned CNT_W     = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_valid_i,
    input  logic [2:0]        exc_class_i,
    input  logic              bank_en_i,
    input  logic              ovf_exc_en_i,
    input  logic [VOFS_W-1:0] vec_ofs_i,
    input  logic [CTX_W-1:0]  ctx_regs_i,
    input  logic              restore_i,
    output logic              bank_save_o,
    output logic              stack_fallback_o,
    output logic              bank_ovf_exc_o,
    output logic              bank_err_o,
    output logic              restore_valid_o,
    output logic [CTX_W-1:0]  rest_ctx_o,
    output logic [VOFS_W-1:0] rest_vofs_o,
    output logic [CNT_W-1:0]  bank_num_o,
    output logic              bank_full_o
);
    import ctxbank_pkg::*;

    localparam int unsigned    SLOT_W = CTX_W + VOFS_W;
    localparam logic [CNT_W-1:0] BN_MAX = CNT_W'(NUM_BANKS);

    typedef struct packed {
        logic [CNT_W-1:0] bn;
        logic             full;
        logic             save;
        logic             fb;
        logic             ovf;
        logic             err;
        logic             rvalid;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              take_bank, take_stack, raise_ovf;
    logic              rd_en;
    logic [CNT_W-1:0]  rd_idx;
    logic [SLOT_W-1:0] rd_slot;

    ctxbank_decide #(
        .NUM_BANKS (NUM_BANKS),
        .CNT_W     (CNT_W)
    ) u_decide (
        .entry_valid (entry_valid_i),
        .exc_class   (exc_class_i),
        .bank_en     (bank_en_i),
        .ovf_en      (ovf_exc_en_i),
        .bank_num    (st_q.bn),
        .take_bank   (take_bank),
        .take_stack  (take_stack),
        .raise_ovf   (raise_ovf)
    );

    always_comb begin
        st_d        = st_q;
        st_d.save   = 1'b0;
        st_d.fb     = 1'b0;
        st_d.ovf    = 1'b0;
        st_d.err    = 1'b0;
        st_d.rvalid = 1'b0;
        rd_en       = 1'b0;
        rd_idx      = st_q.bn - 1'b1;
        if (entry_valid_i) begin
            st_d.save = take_bank;
            st_d.fb   = take_stack;
            st_d.ovf  = raise_ovf;
            if (take_bank)
                st_d.bn = st_q.bn + 1'b1;
        end else if (restore_i) begin
            if (st_q.bn == '0) begin
                st_d.err = 1'b1;
            end else begin
                st_d.bn     = st_q.bn - 1'b1;
                st_d.rvalid = 1'b1;
                rd_en       = 1'b1;
            end
        end
        st_d.full = (st_d.bn == BN_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ctxbank_store #(
        .NUM_BANKS (NUM_BANKS),
        .SLOT_W    (SLOT_W),
        .CNT_W     (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_bank),
        .wr_idx  (st_q.bn),
        .wr_data ({vec_ofs_i, ctx_regs_i}),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .rd_data (rd_slot)
    );

    assign bank_save_o      = st_q.save;
    assign stack_fallback_o = st_q.fb;
    assign bank_ovf_exc_o   = st_q.ovf;
    assign bank_err_o       = st_q.err;
    assign restore_valid_o  = st_q.rvalid;
    assign bank_num_o       = st_q.bn;
    assign bank_full_o      = st_q.full;
    assign rest_ctx_o       = rd_slot[CTX_W-1:0];
    assign rest_vofs_o      = rd_slot[SLOT_W-1:CTX_W];

    AST_BN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bank_num_o <= BN_MAX) else $error("bank number beyond slot count"); // R9
    AST_SAVE_INCR: assert property (@(posedge clk) disable iff (!rst_n)
        bank_save_o |-> (bank_num_o == $past(bank_num_o) + 1'b1)) else $error("save without increment"); // R2
    AST_NONIRQ_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid_i && exc_class_i != EXC_IRQ) |=> (!bank_save_o && !stack_fallback_o && !bank_ovf_exc_o && $stable(bank_num_o)))
        else $error("non-interrupt class touched banks"); // R3
    AST_FB_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_fallback_o || bank_ovf_exc_o) |-> (bank_full_o && $stable(bank_num_o))) else $error("fallback while slots free"); // R5
    AST_ERR_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        bank_err_o |-> (bank_num_o == '0 && !restore_valid_o)) else $error("bank error with slots held"); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_save_o, stack_fallback_o, bank_ovf_exc_o})) else $error("more than one entry outcome"); // R11
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bank_full_o == (bank_num_o == BN_MAX)) else $error("full flag mismatch"); // R9

endmodule

// File: tb/sim_irq_ctx_bank_ctrl.sv
module sim_irq_ctx_bank_ctrl;
    localparam int NB = 3;
    localparam int DW = 8;
    localparam int VW = 6;
    localparam int CW = 19 * DW;
    localparam int NW = $clog2(NB + 1);

    typedef struct {
        string       tag;
        bit          save, fb, ovf, err, rv, full;
        int          bn;
        logic [CW-1:0] ctx;
        logic [VW-1:0] vofs;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic entry_valid = 1'b0;
    logic [2:0] exc_class = '0;
    logic bank_en = 1'b0;
    logic ovf_en = 1'b0;
    logic [VW-1:0] vec_ofs = '0;
    logic [CW-1:0] ctx_regs = '0;
    logic restore = 1'b0;
    logic save_o, fb_o, ovf_o, err_o, rv_o, full_o;
    logic [CW-1:0] rctx_o;
    logic [VW-1:0] rvofs_o;
    logic [NW-1:0] bn_o;

    exp_t exp_q[$];
    logic [CW+VW-1:0] model_stack[$];
    int model_bn = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_ctx_bank_ctrl #(.NUM_BANKS(NB), .DATA_W(DW), .VOFS_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .entry_valid_i(entry_valid), .exc_class_i(exc_class),
        .bank_en_i(bank_en), .ovf_exc_en_i(ovf_en), .vec_ofs_i(vec_ofs), .ctx_regs_i(ctx_regs),
        .restore_i(restore), .bank_save_o(save_o), .stack_fallback_o(fb_o),
        .bank_ovf_exc_o(ovf_o), .bank_err_o(err_o), .restore_valid_o(rv_o),
        .rest_ctx_o(rctx_o), .rest_vofs_o(rvofs_o), .bank_num_o(bn_o), .bank_full_o(full_o)
    );

    function automatic logic [CW-1:0] mk_ctx(int k);
        logic [CW-1:0] r;
        for (int i = 0; i < 19; i++) r[i*DW +: DW] = DW'(k * 19 + i);
        return r;
    endfunction

    task automatic step(input bit ev, input int cls, input bit en, input bit bo,
                        input bit rs, input int k, input string tag);
        exp_t e;
        logic [CW+VW-1:0] slot;
        @(negedge clk);
        entry_valid = ev; exc_class = 3'(cls); bank_en = en; ovf_en = bo;
        restore = rs; ctx_regs = mk_ctx(k); vec_ofs = VW'(k + 10);
        e.tag = tag; e.save = 0; e.fb = 0; e.ovf = 0; e.err = 0; e.rv = 0;
        e.ctx = '0; e.vofs = '0;
        if (ev) begin
            if (cls == 0 && en) begin
                if (model_bn < NB) begin
                    e.save = 1; model_stack.push_back({VW'(k + 10), mk_ctx(k)}); model_bn++;
                end else if (bo) e.ovf = 1;
                else e.fb = 1;
            end
        end else if (rs) begin
            if (model_bn == 0) e.err = 1;
            else begin
                slot = model_stack.pop_back(); model_bn--;
                e.rv = 1; e.ctx = slot[CW-1:0]; e.vofs = slot[CW+VW-1:CW];
            end
        end
        e.bn = model_bn; e.full = (model_bn == NB);
        exp_q.push_back(e);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // monitor: sample 2 ns after the edge that registered the outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (save_o !== e.save || fb_o !== e.fb || ovf_o !== e.ovf || err_o !== e.err ||
                    rv_o !== e.rv || full_o !== e.full || int'(bn_o) != e.bn ||
                    (e.rv && (rctx_o !== e.ctx || rvofs_o !== e.vofs))) begin
                    n_bad++;
                    $display("FAIL %s: save/fb/ovf/err/rv/full=%b%b%b%b%b%b bn=%0d vofs=%h got, exp %b%b%b%b%b%b bn=%0d vofs=%h",
                             e.tag, save_o, fb_o, ovf_o, err_o, rv_o, full_o, bn_o, rvofs_o,
                             e.save, e.fb, e.ovf, e.err, e.rv, e.full, e.bn, e.vofs);
                end
                n_vec++;
                if (int'(save_o) + int'(fb_o) + int'(ovf_o) > 1) begin
                    n_bad++;
                    $display("FAIL R11: outcome pulses %b%b%b got, exp at most one", save_o, fb_o, ovf_o);
                end
            end
        end
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout exp completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1 reset state");
        step(1, 0, 1, 0, 0, 1, "R2 save slot0");
        step(1, 1, 1, 0, 0, 2, "R3 NMI partly filled");
        step(1, 0, 1, 1, 0, 3, "R2 save slot1");
        step(1, 0, 1, 0, 0, 4, "R9 save slot2 full");
        step(1, 2, 1, 1, 0, 5, "R3 user break when full");
        step(1, 0, 1, 0, 0, 6, "R5 full stack fallback");
        step(1, 0, 1, 1, 0, 7, "R6 full overflow exception");
        step(0, 0, 0, 0, 1, 0, "R7 restore slot2 R9 clear full");
        step(1, 0, 1, 0, 1, 8, "R10 entry wins over restore");
        step(0, 0, 1, 0, 1, 0, "R7 restore newest");
        step(0, 0, 1, 0, 1, 0, "R7 restore slot1");
        step(0, 0, 1, 0, 1, 0, "R7 restore slot0");
        step(0, 0, 1, 0, 1, 0, "R8 restore empty");
        step(0, 0, 1, 0, 1, 0, "R8 restore empty again");
        step(1, 0, 0, 0, 0, 9, "R4 banking disabled");
        step(1, 0, 0, 1, 0, 9, "R4 banking disabled ovf en");
        for (int c = 1; c <= 5; c++) step(1, c, 1, 0, 0, 20 + c, "R3 non-interrupt class");
        step(1, 0, 1, 1, 0, 30, "R2 save with ovf en not full");
        step(0, 0, 1, 0, 1, 0, "R7 restore after R3 classes");
        step(0, 0, 0, 0, 0, 0, "R1 idle");
        wait (exp_q.size() == 0);
        @(negedge clk);
        summary();
    end

endmodule